// File: doc/BRIEF.md
# Paged Program Counter Unit

This block keeps the program counter of a small microcontroller core, 13 bits wide, together with a 5-bit high-address latch that software writes before any load that needs the upper address bits. Every clock it picks one of several ways to form the next counter value. It can advance by one or hold. It can take a new low byte from the data path, with the upper bits taken from the latch. It can add an offset to the low byte for table jumps. It can take an 11-bit jump target with two page bits from the latch. It can jump to the interrupt vector, or restore a full address popped from the return stack.

The decoder, ALU, program memory and the stack storage are outside the block. They drive request strobes and data into it and read the counter, the current PC (offered for pushing), the low byte and the latch back out. Software can read the low byte and the latch. The upper five counter bits have no read path.

Top module: `pc_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pc_o`, `lo_rd` and `lat_rd` are all zero.
- R2: With only `inc_en` asserted, the PC becomes the old PC plus one, modulo 8192. Address 0x1FFF wraps to 0x0000.
- R3: On `lo_wr`, the PC becomes {latch[4:0], `lo_wdata`[7:0]}. The latch value used is the one held before the edge.
- R4: On `jmp_ld`, the PC becomes {latch[4:3], `jmp_field`[10:0]}. Latch bits 2:0 have no effect on the result.
- R5: On `cgoto_en`, the PC becomes {latch[4:0], (old PC[7:0] + `cgoto_off`) mod 256}. No carry passes into bit 8.
- R6: On `irq_take`, the PC becomes 0x004. In the cycle of the request, `push_data` equals the PC being replaced.
- R7: On `ret_ld`, the PC becomes `stack_top` in full, and the latch keeps its value.
- R8: `lat_wr` loads all five bits of `lat_wdata` into the latch, which shows on `lat_rd` after the edge. Bit 4 reads back as written. A latch write alone leaves the PC unchanged, and no PC load changes the latch.
- R9: When several loads are requested at once, the winner is chosen in this order: `irq_take`, then `ret_ld`, then `jmp_ld`, then `lo_wr`, then `cgoto_en`, then `inc_en`.
- R10: With no load requested, the PC holds its value.
- R11: `lo_rd` always equals PC bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_en | input | 1 | Advance the PC by one |
| lo_wr | input | 1 | Data-path write of the PC low byte |
| lo_wdata | input | 8 | Low byte value |
| cgoto_en | input | 1 | Add an offset to the low byte |
| cgoto_off | input | 8 | Offset for the computed jump |
| jmp_ld | input | 1 | Jump or call load |
| jmp_field | input | 11 | Target bits 10:0 from the opcode |
| irq_take | input | 1 | Jump to the interrupt vector |
| ret_ld | input | 1 | Restore from the return stack |
| stack_top | input | 13 | Address popped from the stack |
| lat_wr | input | 1 | Write the high-address latch |
| lat_wdata | input | 5 | Latch value |
| pc_o | output | 13 | Current program counter |
| push_data | output | 13 | Current PC, offered for a push |
| lo_rd | output | 8 | Readable PC low byte |
| lat_rd | output | 5 | Readable latch |

## Verification
A wrong latch value shows up only at the next load that uses it. Depending on the path, that is one cycle after a low-byte write, a computed jump or a jump, and `pc_o` then lands in the wrong page. A wrong choice among simultaneous requests, or a counter bit that fails to carry, shows on `pc_o` at the first edge after the stimulus. The sweeps cover every low-byte value, every offset, a spread of jump fields in each page, the full increment wrap, and every combination of request strobes.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int DEF_PC_W  = 13;
    localparam int DEF_LO_W  = 8;
    localparam int DEF_JMP_W = 11;
    localparam int DEF_VEC   = 4;

    // next-PC source, one per load path
    typedef enum logic [2:0] {
        SRC_HOLD  = 3'd0,
        SRC_INC   = 3'd1,
        SRC_CGOTO = 3'd2,
        SRC_LOWR  = 3'd3,
        SRC_JMP   = 3'd4,
        SRC_RET   = 3'd5,
        SRC_VEC   = 3'd6
    } pc_src_e;

endpackage

// File: rtl/pcu_arbiter.sv
module pcu_arbiter
    import pcu_pkg::*;
(
    input  logic    irq_take,
    input  logic    ret_ld,
    input  logic    jmp_ld,
    input  logic    lo_wr,
    input  logic    cgoto_en,
    input  logic    inc_en,
    output pc_src_e sel
);

    always_comb begin
        if (irq_take)      sel = SRC_VEC;
        else if (ret_ld)   sel = SRC_RET;
        else if (jmp_ld)   sel = SRC_JMP;
        else if (lo_wr)    sel = SRC_LOWR;
        else if (cgoto_en) sel = SRC_CGOTO;
        else if (inc_en)   sel = SRC_INC;
        else               sel = SRC_HOLD;
    end

endmodule

// File: rtl/pcu_next.sv
module pcu_next
    import pcu_pkg::*;
#(
    parameter int PC_W  = DEF_PC_W,
    parameter int LO_W  = DEF_LO_W,
    parameter int JMP_W = DEF_JMP_W,
    parameter int VEC   = DEF_VEC,
    localparam int HI_W   = PC_W - LO_W,
    localparam int PAGE_W = PC_W - JMP_W
) (
    input  pc_src_e          sel,
    input  logic [PC_W-1:0]  pc_q,
    input  logic [HI_W-1:0]  lat_q,
    input  logic [LO_W-1:0]  lo_wdata,
    input  logic [LO_W-1:0]  cgoto_off,
    input  logic [JMP_W-1:0] jmp_field,
    input  logic [PC_W-1:0]  stack_top,
    output logic [PC_W-1:0]  pc_d
);

    logic [LO_W-1:0]   lo_sum;
    logic [PAGE_W-1:0] page_bits;

    // low-byte add confined to the byte: carry dropped
    assign lo_sum    = pc_q[LO_W-1:0] + cgoto_off;
    assign page_bits = lat_q[HI_W-1 -: PAGE_W];

    always_comb begin
        unique case (sel)
            SRC_VEC:   pc_d = PC_W'(VEC);
            SRC_RET:   pc_d = stack_top;
            SRC_JMP:   pc_d = {page_bits, jmp_field};
            SRC_LOWR:  pc_d = {lat_q, lo_wdata};
            SRC_CGOTO: pc_d = {lat_q, lo_sum};
            SRC_INC:   pc_d = pc_q + PC_W'(1);
            default:   pc_d = pc_q;
        endcase
    end

endmodule

// File: rtl/pc_unit.sv
module pc_unit
    import pcu_pkg::*;
#(
    parameter int PC_W  = DEF_PC_W,
    parameter int LO_W  = DEF_LO_W,
    parameter int JMP_W = DEF_JMP_W,
    parameter int VEC   = DEF_VEC,
    localparam int HI_W = PC_W - LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic             lo_wr,
    input  logic [LO_W-1:0]  lo_wdata,
    input  logic             cgoto_en,
    input  logic [LO_W-1:0]  cgoto_off,
    input  logic             jmp_ld,
    input  logic [JMP_W-1:0] jmp_field,
    input  logic             irq_take,
    input  logic             ret_ld,
    input  logic [PC_W-1:0]  stack_top,
    input  logic             lat_wr,
    input  logic [HI_W-1:0]  lat_wdata,
    output logic [PC_W-1:0]  pc_o,
    output logic [PC_W-1:0]  push_data,
    output logic [LO_W-1:0]  lo_rd,
    output logic [HI_W-1:0]  lat_rd
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [HI_W-1:0] lat;
    } pcu_state_t;

    pcu_state_t      st_d, st_q;
    pc_src_e         src_sel;
    logic [PC_W-1:0] pc_nxt;

    pcu_arbiter u_arb (
        .irq_take (irq_take),
        .ret_ld   (ret_ld),
        .jmp_ld   (jmp_ld),
        .lo_wr    (lo_wr),
        .cgoto_en (cgoto_en),
        .inc_en   (inc_en),
        .sel      (src_sel)
    );

    pcu_next #(
        .PC_W  (PC_W),
        .LO_W  (LO_W),
        .JMP_W (JMP_W),
        .VEC   (VEC)
    ) u_next (
        .sel       (src_sel),
        .pc_q      (st_q.pc),
        .lat_q     (st_q.lat),
        .lo_wdata  (lo_wdata),
        .cgoto_off (cgoto_off),
        .jmp_field (jmp_field),
        .stack_top (stack_top),
        .pc_d      (pc_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.pc  = pc_nxt;
        if (lat_wr) begin
            st_d.lat = lat_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o      = st_q.pc;
    assign push_data = st_q.pc;
    assign lo_rd     = st_q.pc[LO_W-1:0];
    assign lat_rd    = st_q.lat;

endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int JMP_W = 11,
    parameter int VEC   = 4,
    localparam int HI_W = PC_W - LO_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inc_en,
    input logic             lo_wr,
    input logic [LO_W-1:0]  lo_wdata,
    input logic             cgoto_en,
    input logic             jmp_ld,
    input logic [JMP_W-1:0] jmp_field,
    input logic             irq_take,
    input logic             ret_ld,
    input logic [PC_W-1:0]  stack_top,
    input logic             lat_wr,
    input logic [PC_W-1:0]  pc_o,
    input logic [LO_W-1:0]  lo_rd,
    input logic [HI_W-1:0]  lat_rd
);

    // R6
    vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> pc_o == PC_W'(VEC));

    // R7
    ret_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_ld && !irq_take) |=> pc_o == $past(stack_top));

    // R4
    jmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_ld && !irq_take && !ret_ld)
        |=> pc_o == {$past(lat_rd[HI_W-1 -: PC_W-JMP_W]), $past(jmp_field)});

    // R3
    lowr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !irq_take && !ret_ld && !jmp_ld)
        |=> pc_o == {$past(lat_rd), $past(lo_wdata)});

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !irq_take && !ret_ld && !jmp_ld && !lo_wr && !cgoto_en)
        |=> pc_o == $past(pc_o) + PC_W'(1));

    // R10
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_en && !irq_take && !ret_ld && !jmp_ld && !lo_wr && !cgoto_en)
        |=> $stable(pc_o));

    // R8
    lat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_wr |=> $stable(lat_rd));

    // R11
    lo_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd == pc_o[LO_W-1:0]);

endmodule

bind pc_unit pcu_chk #(
    .PC_W  (PC_W),
    .LO_W  (LO_W),
    .JMP_W (JMP_W),
    .VEC   (VEC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_en    (inc_en),
    .lo_wr     (lo_wr),
    .lo_wdata  (lo_wdata),
    .cgoto_en  (cgoto_en),
    .jmp_ld    (jmp_ld),
    .jmp_field (jmp_field),
    .irq_take  (irq_take),
    .ret_ld    (ret_ld),
    .stack_top (stack_top),
    .lat_wr    (lat_wr),
    .pc_o      (pc_o),
    .lo_rd     (lo_rd),
    .lat_rd    (lat_rd)
);

// File: tb/sim_pc_unit.sv
module sim_pc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_en = 1'b0, lo_wr = 1'b0, cgoto_en = 1'b0, jmp_ld = 1'b0;
    logic        irq_take = 1'b0, ret_ld = 1'b0, lat_wr = 1'b0;
    logic [7:0]  lo_wdata = '0, cgoto_off = '0;
    logic [10:0] jmp_field = '0;
    logic [12:0] stack_top = '0;
    logic [4:0]  lat_wdata = '0;
    logic [12:0] pc_o, push_data;
    logic [7:0]  lo_rd;
    logic [4:0]  lat_rd;

    int total = 0;
    int bad = 0;
    logic [12:0] m_pc = '0;
    logic [4:0]  m_lat = '0;

    always #4 clk = ~clk;

    pc_unit u0 (
        .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .lo_wr(lo_wr),
        .lo_wdata(lo_wdata), .cgoto_en(cgoto_en), .cgoto_off(cgoto_off),
        .jmp_ld(jmp_ld), .jmp_field(jmp_field), .irq_take(irq_take),
        .ret_ld(ret_ld), .stack_top(stack_top), .lat_wr(lat_wr),
        .lat_wdata(lat_wdata), .pc_o(pc_o), .push_data(push_data),
        .lo_rd(lo_rd), .lat_rd(lat_rd)
    );

    task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic clr();
        inc_en = 0; lo_wr = 0; cgoto_en = 0; jmp_ld = 0;
        irq_take = 0; ret_ld = 0; lat_wr = 0;
    endtask

    // inputs already set after a negedge; apply one edge and compare
    task automatic step(input string req);
        logic [12:0] e;
        if (irq_take) chk("R6 push", push_data, m_pc);
        if (irq_take)      e = 13'h004;
        else if (ret_ld)   e = stack_top;
        else if (jmp_ld)   e = {m_lat[4:3], jmp_field};
        else if (lo_wr)    e = {m_lat, lo_wdata};
        else if (cgoto_en) e = {m_lat, m_pc[7:0] + cgoto_off};
        else if (inc_en)   e = m_pc + 13'd1;
        else               e = m_pc;
        @(posedge clk);
        m_pc = e;
        if (lat_wr) m_lat = lat_wdata;
        #1;
        chk(req, pc_o, m_pc);
        chk({req, " latch"}, {8'd0, lat_rd}, {8'd0, m_lat});
        chk("R11", {5'd0, lo_rd}, {5'd0, m_pc[7:0]});
        @(negedge clk);
        clr();
    endtask

    task automatic set_lat(input logic [4:0] v);
        lat_wr = 1; lat_wdata = v;
        step("R8");
    endtask

    task automatic set_pc(input logic [12:0] v);
        ret_ld = 1; stack_top = v;
        step("R7");
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1", pc_o, 13'd0);
        chk("R1", {8'd0, lat_rd}, 13'd0);
        rst_n = 1;
        @(posedge clk); #1;
        chk("R1", pc_o, 13'd0);
        chk("R1", {5'd0, lo_rd}, 13'd0);
        @(negedge clk);

        // R2: full walk with wrap
        for (int i = 0; i < 8193; i++) begin
            inc_en = 1;
            step("R2");
        end

        // R8: latch bit patterns incl. bit 4, PC unchanged
        for (int v = 0; v < 32; v++) set_lat(5'(v));

        // R3: every low byte under several latch values
        for (int l = 0; l < 4; l++) begin
            set_lat(l == 0 ? 5'h00 : l == 1 ? 5'h1F : l == 2 ? 5'h15 : 5'h0A);
            for (int b = 0; b < 256; b++) begin
                lo_wr = 1; lo_wdata = 8'(b);
                if (b % 7 == 0) begin lat_wr = 1; lat_wdata = m_lat; end
                step("R3");
            end
        end

        // R4: jump fields across all pages, low latch bits vary
        for (int l = 0; l < 32; l++) begin
            set_lat(5'(l));
            for (int f = 0; f < 2048; f += 61) begin
                jmp_ld = 1; jmp_field = 11'(f);
                step("R4");
            end
        end

        // R5: every offset from a high low-byte, page from latch
        set_lat(5'h13);
        for (int o = 0; o < 256; o++) begin
            set_pc(13'h02F0);
            cgoto_en = 1; cgoto_off = 8'(o);
            step("R5");
        end

        // R6 and R7
        set_pc(13'h1ABC);
        irq_take = 1; step("R6");
        set_lat(5'h0C);
        ret_ld = 1; stack_top = 13'h1FFF; step("R7");
        ret_ld = 1; stack_top = 13'h0000; step("R7");

        // R10: hold with nothing asserted
        for (int i = 0; i < 4; i++) step("R10");

        // R9: every combination of request strobes
        set_lat(5'h19);
        for (int c = 0; c < 64; c++) begin
            set_pc(13'(c * 97 + 300));
            irq_take = c[5]; ret_ld = c[4]; jmp_ld = c[3];
            lo_wr = c[2]; cgoto_en = c[1]; inc_en = c[0];
            stack_top = 13'h0BEE; jmp_field = 11'h5A5;
            lo_wdata = 8'h3C; cgoto_off = 8'hC7;
            lat_wr = c[0]; lat_wdata = 5'h19;
            step("R9");
        end

        // R1: reset from a non-zero state
        set_lat(5'h1F);
        set_pc(13'h1234);
        rst_n = 0;
        #1;
        chk("R1", pc_o, 13'd0);
        chk("R1", {8'd0, lat_rd}, 13'd0);
        m_pc = '0; m_lat = '0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule